// File: doc/BRIEF.md
# Power-Management Event and Control Register File

This block is the register file of a power-management event group. Software reaches it over a simple I/O port. It holds four things: a status register, whose bits latch hardware events; an enable register, which selects the events that may raise the system control interrupt; a control register, which carries the interrupt master enable, a lock-release bit, a 3-bit sleep-type field and a self-clearing sleep trigger; and a free-running timer that can only be read.

Each access selects one 32-bit word with `io_addr` and marks the bytes it touches with `io_be`. A byte, halfword or full-word access at a given offset is therefore one strobe with the matching byte enables. Word 0 packs status into bits 15:0 and enable into bits 31:16. Word 1 holds control in bits 15:0. Word 2 holds the timer. Read data is registered. It is presented on `io_rdata` in the cycle after the read strobe and holds until the next read.

Status bits are set by two events. The first is a flip of the timer's most significant bit. The second is a pulse on `gbl_evt`. Software clears a status bit by writing a one to it. A write of one to the sleep trigger produces a one-cycle request that carries the sleep type written in the same access.

Top module: `pm_evt_regs`

## Requirements
- R1: After reset, word 0 reads 0x00000000, word 1 reads 0x00000001 (only the interrupt master enable, control bit 0, is set), `sci_irq` is 0 and `slp_req` is 0.
- R2: Read data appears on `io_rdata` one clock after the read strobe. Word 0 returns {enable, status}. Word 1 returns control in bits 15:0 and zero above. Word 3 returns 0.
- R3: Status bit 0 (timer overflow) and status bit 5 (global event) clear when a write to word 0 with byte enable 0 has a one in that bit position. A zero in that position, or a write without byte enable 0, leaves the bit unchanged.
- R4: Enable writes are merged per byte. Bits 7:0 come from data byte 2 when `io_be[2]` is set, and bits 15:8 come from data byte 3 when `io_be[3]` is set. Control works the same way with `io_be[0]` and `io_be[1]`. Bytes that are not enabled keep their value. One full-word write to word 0 updates enable and applies the status clear in the same cycle.
- R5: The timer counts up by one every clock. It reads back zero-extended to 32 bits, and writes to word 2 have no effect on it.
- R6: Status bit 0 is set at the clock edge where the timer's most significant bit changes, in both directions.
- R7: A one on `gbl_evt` at a clock edge sets status bit 5.
- R8: If an event and a software clear of the same status bit arrive in the same cycle, the bit ends set.
- R9: `sci_irq` is high exactly when control bit 0 is set and some status bit is set together with the enable bit at the same position.
- R10: A write to word 1 with `io_be[1]` set and data bit 13 at one drives `slp_req` high for the following cycle only. In that cycle `slp_typ` equals data bits 12:10 of the same write. Control bit 13 always reads 0, and bits 12:10 keep the written type.
- R11: Status bits other than 0 and 5 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_stb | input | 1 | Access strobe, one access per cycle it is high |
| io_wr | input | 1 | 1 write, 0 read |
| io_addr | input | ADDR_W | 32-bit word index (0 event, 1 control, 2 timer) |
| io_be | input | 4 | Byte enables for the four data lanes |
| io_wdata | input | 32 | Write data, byte n on bits 8n+7:8n |
| io_rdata | output | 32 | Registered read data |
| gbl_evt | input | 1 | Global event pulse, sets status bit 5 |
| sci_irq | output | 1 | System control interrupt |
| slp_req | output | 1 | One-cycle sleep request |
| slp_typ | output | 3 | Sleep type that goes with the request |

## Verification
A hardware event and a software write-one-to-clear can hit the same status bit in the same cycle. The bench drives `gbl_evt` in the same cycle as a word-0 write that clears bit 5, and expects the bit still set on the next read. For the timer-overflow bit, the bench computes the exact edge of the next most-significant-bit flip from a timer read. It then reads status on that edge and on the one after, and expects 0 and then 1. This pins down both the timing of the event and the fact that it does not collide with pending accesses.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
   localparam int REG_W    = 16;
   localparam int DATA_W   = 32;
   localparam int LANE_W   = 8;
   localparam int TYP_W    = 3;

   // status event positions (enable uses the same positions)
   localparam int STS_TMR_BIT = 0;
   localparam int STS_GBL_BIT = 5;
   localparam logic [REG_W-1:0] STS_IMPL = 16'h0021;

   // control layout
   localparam int CTL_SCI_BIT = 0;
   localparam int CTL_TYP_LO  = 10;
   localparam int CTL_SLP_BIT = 13;
   localparam logic [REG_W-1:0] CTL_RESET = 16'h0001;
   localparam logic [REG_W-1:0] CTL_WMASK = 16'hDFFF;

   localparam logic [REG_W-1:0] EN_RESET  = 16'h0000;
   localparam logic [REG_W-1:0] EN_WMASK  = 16'hFFFF;

   typedef enum logic [1:0] {
      WSEL_EVT  = 2'd0,
      WSEL_CTL  = 2'd1,
      WSEL_TMR  = 2'd2,
      WSEL_NONE = 2'd3
   } wsel_e;

   typedef struct packed {
      logic [1:0] sts;
      logic [1:0] en;
      logic [1:0] ctl;
   } lane_we_t;
endpackage

// File: rtl/pm_tick_ctr.sv
module pm_tick_ctr #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count,
   output logic         msb_flip
);
   if (W < 2 || W > 32) begin : g_bad_w
      $error("pm_tick_ctr: W must lie in 2..32");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

   // the top bit changes on the edge where all lower bits wrap
   assign msb_flip = &count[W-2:0];
endmodule

// File: rtl/pm_bus_decode.sv
module pm_bus_decode
   import pm_evt_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              io_stb,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [3:0]        io_be,
   output lane_we_t          we,
   output wsel_e             rsel,
   output logic              rd
);
   if (ADDR_W < 2) begin : g_bad_aw
      $error("pm_bus_decode: ADDR_W must be at least 2");
   end

   logic hit;
   if (ADDR_W > 2) begin : g_wide
      assign hit = (io_addr[ADDR_W-1:2] == '0);
   end else begin : g_narrow
      assign hit = 1'b1;
   end

   always_comb begin
      rsel = WSEL_NONE;
      if (hit) begin
         unique case (io_addr[1:0])
            2'd0:    rsel = WSEL_EVT;
            2'd1:    rsel = WSEL_CTL;
            2'd2:    rsel = WSEL_TMR;
            default: rsel = WSEL_NONE;
         endcase
      end
   end

   logic wr_go;
   assign wr_go = io_stb & io_wr;
   assign rd    = io_stb & ~io_wr;

   always_comb begin
      we = '0;
      if (wr_go && rsel == WSEL_EVT) begin
         we.sts = io_be[1:0];
         we.en  = io_be[3:2];
      end
      if (wr_go && rsel == WSEL_CTL) begin
         we.ctl = io_be[1:0];
      end
   end
endmodule

// File: rtl/pm_lane_reg.sv
module pm_lane_reg #(
   parameter int              REG_W = 16,
   parameter int              LN_W  = 8,
   parameter logic [REG_W-1:0] RST  = '0,
   parameter logic [REG_W-1:0] WMSK = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_W/LN_W-1:0] we,
   input  logic [REG_W-1:0]      wd,
   output logic [REG_W-1:0]      q
);
   localparam int LANES = REG_W / LN_W;

   if (LANES * LN_W != REG_W) begin : g_bad_split
      $error("pm_lane_reg: REG_W must be a multiple of LN_W");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[l*LN_W +: LN_W] <= RST[l*LN_W +: LN_W];
         else if (we[l])
            q[l*LN_W +: LN_W] <= wd[l*LN_W +: LN_W] & WMSK[l*LN_W +: LN_W];
      end
   end
endmodule

// File: rtl/pm_sts_w1c.sv
module pm_sts_w1c #(
   parameter int               REG_W = 16,
   parameter int               LN_W  = 8,
   parameter logic [REG_W-1:0] IMPL  = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_W/LN_W-1:0] we,
   input  logic [REG_W-1:0]      wd,
   input  logic [REG_W-1:0]      set_vec,
   output logic [REG_W-1:0]      q
);
   localparam int LANES = REG_W / LN_W;

   if (LANES * LN_W != REG_W) begin : g_bad_split
      $error("pm_sts_w1c: REG_W must be a multiple of LN_W");
   end

   logic [REG_W-1:0] clr;
   for (genvar l = 0; l < LANES; l++) begin : g_clr
      assign clr[l*LN_W +: LN_W] = we[l] ? wd[l*LN_W +: LN_W] : '0;
   end

   // events win over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= ((q & ~clr) | set_vec) & IMPL;
   end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
   import pm_evt_pkg::*;
#(
   parameter int TMR_W  = 24,
   parameter int ADDR_W = 2,
   parameter bit RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_stb,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [3:0]        io_be,
   input  logic [31:0]       io_wdata,
   output logic [31:0]       io_rdata,
   input  logic              gbl_evt,
   output logic              sci_irq,
   output logic              slp_req,
   output logic [2:0]        slp_typ
);
   localparam int LANES = REG_W / LANE_W;

   if (TMR_W > DATA_W) begin : g_bad_tmr
      $error("pm_evt_regs: TMR_W exceeds the data width");
   end

   lane_we_t we;
   wsel_e    rsel;
   logic     rd;

   pm_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .io_stb (io_stb),
      .io_wr  (io_wr),
      .io_addr(io_addr),
      .io_be  (io_be),
      .we     (we),
      .rsel   (rsel),
      .rd     (rd)
   );

   // free-running timer
   logic [TMR_W-1:0] tmr_cnt;
   logic             tmr_flip;

   pm_tick_ctr #(.W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (tmr_cnt),
      .msb_flip(tmr_flip)
   );

   // status: hardware set, software write-one clear
   logic [REG_W-1:0] sts_set, sts_q;
   always_comb begin
      sts_set              = '0;
      sts_set[STS_TMR_BIT] = tmr_flip;
      sts_set[STS_GBL_BIT] = gbl_evt;
   end

   pm_sts_w1c #(.REG_W(REG_W), .LN_W(LANE_W), .IMPL(STS_IMPL)) u_sts (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we.sts),
      .wd     (io_wdata[REG_W-1:0]),
      .set_vec(sts_set),
      .q      (sts_q)
   );

   // enable: plain byte-merged register in the upper half of word 0
   logic [REG_W-1:0] en_q;
   pm_lane_reg #(.REG_W(REG_W), .LN_W(LANE_W), .RST(EN_RESET), .WMSK(EN_WMASK)) u_en (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (we.en[LANES-1:0]),
      .wd   (io_wdata[DATA_W-1:REG_W]),
      .q    (en_q)
   );

   // control: byte-merged, trigger bit never stored
   logic [REG_W-1:0] ctrl_q;
   pm_lane_reg #(.REG_W(REG_W), .LN_W(LANE_W), .RST(CTL_RESET), .WMSK(CTL_WMASK)) u_ctl (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (we.ctl[LANES-1:0]),
      .wd   (io_wdata[REG_W-1:0]),
      .q    (ctrl_q)
   );

   // sleep trigger: the type travels with the write that fires it
   localparam int SLP_LANE = CTL_SLP_BIT / LANE_W;
   logic slp_go;
   assign slp_go = we.ctl[SLP_LANE] & io_wdata[CTL_SLP_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slp_req <= 1'b0;
         slp_typ <= '0;
      end else begin
         slp_req <= slp_go;
         if (slp_go) slp_typ <= io_wdata[CTL_TYP_LO +: TYP_W];
      end
   end

   // interrupt
   assign sci_irq = ctrl_q[CTL_SCI_BIT] & (|(sts_q & en_q));

   // read path
   logic [DATA_W-1:0] rword;
   always_comb begin
      unique case (rsel)
         WSEL_EVT: rword = {en_q, sts_q};
         WSEL_CTL: rword = {{(DATA_W-REG_W){1'b0}}, ctrl_q};
         WSEL_TMR: rword = DATA_W'(tmr_cnt);
         default:  rword = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  io_rdata <= '0;
         else if (rd) io_rdata <= rword;
      end
   end else begin : g_rd_comb
      assign io_rdata = rword;
   end
endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk #(
   parameter int TMR_W  = 24,
   parameter int ADDR_W = 2,
   parameter bit RD_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_stb,
   input logic              io_wr,
   input logic [ADDR_W-1:0] io_addr,
   input logic              be0,
   input logic              be1,
   input logic              wd_tmr,
   input logic              wd_gbl,
   input logic              wd_slp,
   input logic              rd_slp,
   input logic              gbl_evt,
   input logic              sci_irq,
   input logic              slp_req,
   input logic              ctrl_sci,
   input logic [15:0]       sts_q,
   input logic [TMR_W-1:0]  tmr_cnt,
   input logic              tmr_flip
);
   logic pv;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   logic w0_wr, w1_wr, w1_rd;
   assign w0_wr = io_stb & io_wr & (io_addr == ADDR_W'(0));
   assign w1_wr = io_stb & io_wr & (io_addr == ADDR_W'(1));
   assign w1_rd = io_stb & ~io_wr & (io_addr == ADDR_W'(1));

   p_sts_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q & 16'hFFDE) == 16'h0000);

   p_w1c_tmr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (w0_wr && be0 && wd_tmr && !tmr_flip) |=> !sts_q[0]);

   p_w1c_gbl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (w0_wr && be0 && wd_gbl && !gbl_evt) |=> !sts_q[5]);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gbl_evt |=> sts_q[5]);

   p_tmr_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && $rose(sts_q[0])) |-> $past(tmr_flip));

   p_tmr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> (tmr_cnt == TMR_W'($past(tmr_cnt) + 1'b1)));

   p_slp_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && slp_req) |-> $past(w1_wr && be1 && wd_slp));

   p_sci_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_sci || sts_q == 16'h0000) |-> !sci_irq);

   if (RD_REG) begin : g_rd_chk
      p_slp_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (pv && $past(w1_rd)) |-> !rd_slp);
   end
endmodule

bind pm_evt_regs pm_evt_regs_chk #(
   .TMR_W (TMR_W),
   .ADDR_W(ADDR_W),
   .RD_REG(RD_REG)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .io_stb  (io_stb),
   .io_wr   (io_wr),
   .io_addr (io_addr),
   .be0     (io_be[0]),
   .be1     (io_be[1]),
   .wd_tmr  (io_wdata[0]),
   .wd_gbl  (io_wdata[5]),
   .wd_slp  (io_wdata[13]),
   .rd_slp  (io_rdata[13]),
   .gbl_evt (gbl_evt),
   .sci_irq (sci_irq),
   .slp_req (slp_req),
   .ctrl_sci(ctrl_q[0]),
   .sts_q   (sts_q),
   .tmr_cnt (tmr_cnt),
   .tmr_flip(tmr_flip)
);

// File: tb/tb_pm_evt_regs.sv
module tb_pm_evt_regs;
   localparam int CLK_P = 10;
   localparam int TW    = 16;
   localparam int HALF  = 1 << (TW - 1);

   logic        clk, rst_n, io_stb, io_wr, gbl_evt;
   logic [1:0]  io_addr;
   logic [3:0]  io_be;
   logic [31:0] io_wdata, io_rdata;
   logic        sci_irq, slp_req;
   logic [2:0]  slp_typ;

   pm_evt_regs #(.TMR_W(TW), .ADDR_W(2), .RD_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .io_stb(io_stb), .io_wr(io_wr),
      .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .gbl_evt(gbl_evt), .sci_irq(sci_irq),
      .slp_req(slp_req), .slp_typ(slp_typ)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   int nchk = 0, nfail = 0;
   logic [31:0] rd_v;
   logic [15:0] en_m, ctrl_m;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one access on the next rising edge; read data sampled just after it
   task automatic io(input bit wr, input logic [1:0] a, input logic [3:0] be,
                     input logic [31:0] d, input bit evt);
      @(negedge clk);
      io_stb = 1'b1; io_wr = wr; io_addr = a; io_be = be; io_wdata = d; gbl_evt = evt;
      @(posedge clk); #1;
      rd_v   = io_rdata;
      io_stb = 1'b0; gbl_evt = 1'b0;
   endtask

   task automatic idle(input int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic evt_pulse();
      @(negedge clk); gbl_evt = 1'b1;
      @(posedge clk); #1; gbl_evt = 1'b0;
   endtask

   task automatic overflow_probe(input string tag);
      int n;
      io(0, 2'd2, 4'hF, 0, 0);
      n = HALF - 1 - int'(rd_v[TW-2:0]);
      if (n < 2) n += HALF;
      idle(n - 1);
      io(0, 2'd0, 4'hF, 0, 0);
      chk({tag, " R6 status bit0 before flip"}, {31'h0, rd_v[0]}, 32'h0);
      io(0, 2'd0, 4'hF, 0, 0);
      chk({tag, " R6 status bit0 after flip"}, {31'h0, rd_v[0]}, 32'h1);
   endtask

   initial begin
      #(CLK_P * 180000);
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] t1, t2, t3, d;
      logic [3:0]  b;
      rst_n = 1'b0; io_stb = 1'b0; io_wr = 1'b0; io_addr = '0; io_be = '0;
      io_wdata = '0; gbl_evt = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 sci_irq", {31'h0, sci_irq}, 32'h0);
      chk("R1 slp_req", {31'h0, slp_req}, 32'h0);
      io(0, 2'd0, 4'hF, 0, 0); chk("R1 word0", rd_v, 32'h0);
      io(0, 2'd1, 4'hF, 0, 0); chk("R1 word1", rd_v, 32'h1);
      io(0, 2'd3, 4'hF, 0, 0); chk("R2 word3 reads zero", rd_v, 32'h0);
      en_m = 16'h0; ctrl_m = 16'h0001;

      // R5 timer stepping, zero extension, write ignored
      io(0, 2'd2, 4'hF, 0, 0); t1 = rd_v;
      idle(6);
      io(0, 2'd2, 4'hF, 0, 0); t2 = rd_v;
      chk("R5 timer delta", 32'(t2[TW-1:0] - t1[TW-1:0]), 32'd7);
      chk("R5 upper bits zero", {16'h0, t2[31:16]}, 32'h0);
      io(1, 2'd2, 4'hF, 32'hFFFF_FFFF, 0);
      io(0, 2'd2, 4'hF, 0, 0); t3 = rd_v;
      chk("R5 write ignored", 32'(t3[TW-1:0] - t2[TW-1:0]), 32'd2);

      // R4 enable byte merge over every byte-enable pattern
      for (int i = 0; i < 16; i++) begin
         b = 4'(i);
         d = {16'hC3A5 ^ 16'(i * 16'h1B37), 16'h0000};
         io(1, 2'd0, b, d, 0);
         if (b[2]) en_m[7:0]  = d[23:16];
         if (b[3]) en_m[15:8] = d[31:24];
         io(0, 2'd0, 4'hF, 0, 0);
         chk($sformatf("R4 enable merge be=%h", b), rd_v, {en_m, 16'h0000});
      end

      // R4 control byte merge; trigger bit kept clear here
      for (int i = 0; i < 16; i++) begin
         b = 4'(i);
         d = (32'h6B1E_94D7 ^ 32'(i * 32'h0107_2309)) & ~32'h0000_2000;
         io(1, 2'd1, b, d, 0);
         if (b[0]) ctrl_m[7:0]  = d[7:0];
         if (b[1]) ctrl_m[15:8] = d[15:8] & 8'hDF;
         io(0, 2'd1, 4'hF, 0, 0);
         chk($sformatf("R4 control merge be=%h", b), rd_v, {16'h0, ctrl_m});
      end

      // known base: interrupt master enable only, enables cleared
      io(1, 2'd1, 4'h3, 32'h0000_0001, 0); ctrl_m = 16'h0001;
      io(1, 2'd0, 4'hC, 32'h0000_0000, 0); en_m = 16'h0;

      // R7 global event, R9 interrupt gating
      evt_pulse();
      io(0, 2'd0, 4'hF, 0, 0); chk("R7 global status set", rd_v, 32'h0000_0020);
      chk("R9 no enable no irq", {31'h0, sci_irq}, 32'h0);
      io(1, 2'd0, 4'h4, 32'h0020_0000, 0);
      chk("R9 enable raises irq", {31'h0, sci_irq}, 32'h1);
      io(1, 2'd1, 4'h1, 32'h0000_0000, 0);
      chk("R9 master enable off", {31'h0, sci_irq}, 32'h0);
      io(1, 2'd1, 4'h1, 32'h0000_0001, 0);
      chk("R9 master enable on", {31'h0, sci_irq}, 32'h1);

      // R3 write-one-to-clear, R11 reserved bits
      io(1, 2'd0, 4'h3, 32'h0000_0000, 0);
      io(0, 2'd0, 4'hF, 0, 0); chk("R3 zero write keeps", rd_v, 32'h0020_0020);
      io(1, 2'd0, 4'h3, 32'h0000_FFDE, 0);
      io(0, 2'd0, 4'hF, 0, 0); chk("R11 reserved ignored", rd_v, 32'h0020_0020);
      io(1, 2'd0, 4'h2, 32'h0000_0020, 0);
      io(0, 2'd0, 4'hF, 0, 0); chk("R3 wrong lane keeps", rd_v, 32'h0020_0020);
      io(1, 2'd0, 4'h1, 32'h0000_0020, 0);
      chk("R9 irq drops after clear", {31'h0, sci_irq}, 32'h0);
      io(0, 2'd0, 4'hF, 0, 0); chk("R3 one clears", rd_v, 32'h0020_0000);

      // R8 event and clear in the same cycle
      evt_pulse();
      io(1, 2'd0, 4'h1, 32'h0000_0020, 1);
      io(0, 2'd0, 4'hF, 0, 0); chk("R8 set wins", rd_v, 32'h0020_0020);
      io(1, 2'd0, 4'h1, 32'h0000_0020, 0);
      io(0, 2'd0, 4'hF, 0, 0); chk("R8 later clear", rd_v, 32'h0020_0000);

      // R4 full-word write updates enable and clears status together
      evt_pulse();
      io(1, 2'd0, 4'hF, 32'h0021_0020, 0); en_m = 16'h0021;
      io(0, 2'd0, 4'hF, 0, 0); chk("R4 packed word write", rd_v, 32'h0021_0000);

      // R10 sleep trigger for every type
      for (int t = 0; t < 8; t++) begin
         io(1, 2'd1, 4'h2, 32'(t << 10) | 32'h0000_2000, 0);
         chk($sformatf("R10 pulse t=%0d", t), {31'h0, slp_req}, 32'h1);
         chk($sformatf("R10 type t=%0d", t), {29'h0, slp_typ}, 32'(t));
         idle(1);
         chk($sformatf("R10 single cycle t=%0d", t), {31'h0, slp_req}, 32'h0);
         io(0, 2'd1, 4'hF, 0, 0);
         chk($sformatf("R10 readback t=%0d", t), rd_v, 32'(t << 10) | 32'h1);
      end
      io(1, 2'd1, 4'h2, 32'h0000_0400, 0);
      chk("R10 zero trigger no pulse", {31'h0, slp_req}, 32'h0);
      io(1, 2'd1, 4'h1, 32'h0000_2001, 0);
      chk("R10 lane off no pulse", {31'h0, slp_req}, 32'h0);

      // R6 timer overflow in both directions of the top bit
      io(1, 2'd0, 4'h1, 32'h0000_0001, 0);
      overflow_probe("rise");
      chk("R9 overflow raises irq", {31'h0, sci_irq}, 32'h1);
      io(1, 2'd0, 4'h1, 32'h0000_0001, 0);
      io(0, 2'd0, 4'hF, 0, 0); chk("R3 overflow cleared", rd_v, 32'h0021_0000);
      overflow_probe("fall");

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule